// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block guards a chip against software that has stopped making progress. Once started, a 24-bit down-counter is stepped by a fixed divide-by-4 prescaler on the watchdog clock. Software must service the watchdog with a two-write unlock pattern before the counter runs out. An optional window rejects service that arrives while the count is still outside a programmed band. An optional warning flag fires at a programmed count ahead of expiry. A wrong service pattern is treated exactly like an expiry.

A sticky mode bit picks what a fault does. With the bit clear, the watchdog stops and raises a time-out flag on the interrupt output. With the bit set, the watchdog drives its reset output for one clock and returns every setting to its reset value, except a flag that records the watchdog-caused reset. Software cannot clear the enable or the mode bit. Only the external reset or a watchdog fault returns them to zero.

Register map (word address on `acc_addr`): 0 control/status, 1 time-out constant, 2 service port (write only, reads 0), 3 live count (read only), 4 warning count, 5 window lower bound, 6 window upper bound. Control bits: 0 running, 1 reset mode, 2 time-out flag, 3 warning flag, 4 watchdog-reset record, 5 window enable. The controller is a four-state machine:
- IDLE (`ST_OFF`) goes to COUNTING (`ST_RUN`) on a control write with bit 0 set.
- COUNTING goes to HALF-KEYED (`ST_ARMED`) on a service write of 0xAA.
- HALF-KEYED goes back to COUNTING on a service write of 0x55 that passes the window check.
- Any fault leads to TRIPPING (`ST_TRIP`) in reset mode, or to IDLE otherwise.
- TRIPPING always goes to IDLE after one cycle.

Top module: `wwdt_top`

## Requirements
- R1: After the external reset, `wdt_rst_o` and `wdt_irq_o` are 0. The control register reads 0, the live count reads 0 and the time-out constant reads 0x00FFFF.
- R2: While running, the live count falls by one every 4 clocks. A fault caused by expiry occurs exactly 4×N clocks after the counter was loaded with N.
- R3: A write of 0xAA to address 2, followed directly by a write of 0x55 to address 2, reloads the live count from the time-out constant.
- R4: Writing 0 to control bit 0 while running has no effect. The watchdog keeps counting, and control bit 0 still reads 1.
- R5: When the live count steps from W+1 to W (W = warning count), control bit 3 sets and `wdt_irq_o` goes high.
- R6: Writing 1 to control bit 2, 3 or 4 clears that flag. Writing 0 leaves it unchanged.
- R7: With control bit 1 clear, a fault stops the counter, clears control bit 0, sets control bit 2 and raises `wdt_irq_o`.
- R8: A first service write other than 0xAA is a fault. After 0xAA, any read or write other than 0x55 to address 2 is a fault.
- R9: With control bit 5 set, a 0x55 service write is accepted only if lower bound ≤ live count ≤ upper bound. Otherwise it is a fault.
- R10: With control bit 1 set, a fault drives `wdt_rst_o` high for exactly one clock. After that, every register holds its reset value except control bit 4, which reads 1.
- R11: Once control bit 1 is set, writing 0 to it has no effect.
- R12: A time-out constant written below 256 is stored as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | External active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 3 | Register word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational on address) |
| wdt_rst_o | output | 1 | One-clock reset request |
| wdt_irq_o | output | 1 | Time-out or warning interrupt |

## Verification
The bound checker watches, on every clock:
- that the count only holds or steps down by one between loads,
- that a load takes the time-out constant,
- that the enable and reset-mode bits survive anything but a fault,
- that the reset pulse lasts one clock and leaves the record flag set,
- that the stored constant never drops below 256.

Only the bench scenarios can show the remaining behaviour:
- the exact expiry and warning cycles,
- the rejection of broken or early service patterns,
- the window bounds,
- the write-1-to-clear flag behaviour.

The bench shows these by comparing the outputs against a behavioural model every clock.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2,
        ST_TRIP  = 2'd3
    } wwdt_state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_FEED   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_WARN   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_WINLO  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_WINHI  = 3'd6;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int CB_EN   = 0;
    localparam int CB_MODE = 1;
    localparam int CB_TOUT = 2;
    localparam int CB_WARN = 3;
    localparam int CB_RSTF = 4;
    localparam int CB_WIN  = 5;
endpackage

// File: rtl/wwdt_timer.sv
module wwdt_timer #(
    parameter int CNT_W = 24,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] warn_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             warn_hit
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    logic [PRE_W-1:0] pre;
    logic             tick;

    assign tick     = run && (pre == PRE_LAST);
    assign expire   = tick && (cnt == CNT_W'(1));
    assign warn_hit = tick && ({1'b0, cnt} == ({1'b0, warn_val} + (CNT_W+1)'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (clear) begin
            pre <= '0;
            cnt <= '0;
        end else if (load) begin
            pre <= '0;
            cnt <= load_val;
        end else if (run) begin
            pre <= pre + 1'b1;
            if (tick) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wwdt_fsm.sv
module wwdt_fsm
    import wwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        key,
    input  logic              start_req,
    input  logic              expire,
    input  logic              win_ok,
    input  logic              rst_mode,
    output wwdt_state_e       state,
    output logic              load,
    output logic              fault,
    output logic              trip
);
    wwdt_state_e nxt;
    logic        feed_wr;

    assign feed_wr = acc_wr && (acc_addr == ADR_FEED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt   = state;
        load  = 1'b0;
        fault = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (start_req) begin
                    nxt  = ST_RUN;
                    load = 1'b1;
                end
            end
            ST_RUN: begin
                if (feed_wr) begin
                    if (key == KEY_FIRST) nxt = ST_ARMED;
                    else                  fault = 1'b1;
                end else if (expire) begin
                    fault = 1'b1;
                end
            end
            ST_ARMED: begin
                if (feed_wr && key == KEY_SECOND) begin
                    if (win_ok) begin
                        nxt  = ST_RUN;
                        load = 1'b1;
                    end else begin
                        fault = 1'b1;
                    end
                end else if (acc_wr || acc_rd) begin
                    fault = 1'b1;
                end else if (expire) begin
                    fault = 1'b1;
                end
            end
            ST_TRIP: nxt = ST_OFF;
            default: nxt = ST_OFF;
        endcase
        if (fault) nxt = rst_mode ? ST_TRIP : ST_OFF;
    end

    always_comb trip = (state == ST_TRIP);
endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
    import wwdt_pkg::*;
#(
    parameter int                CNT_W      = 24,
    parameter int                DATA_W     = 32,
    parameter int                MIN_RELOAD = 256,
    parameter logic [CNT_W-1:0]  RELOAD_RST = 24'h00FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              set_tout,
    input  logic              set_warn,
    output logic              rst_mode,
    output logic              win_en,
    output logic              tout_f,
    output logic              warn_f,
    output logic              rstrec_f,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  warn_q,
    output logic [CNT_W-1:0]  winlo_q,
    output logic [CNT_W-1:0]  winhi_q
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

    logic [CNT_W-1:0] wval;
    assign wval = acc_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_mode <= 1'b0; win_en <= 1'b0;
            tout_f   <= 1'b0; warn_f <= 1'b0; rstrec_f <= 1'b0;
            reload_q <= RELOAD_RST; warn_q <= '0; winlo_q <= '0; winhi_q <= '0;
        end else if (clear) begin
            rst_mode <= 1'b0; win_en <= 1'b0;
            tout_f   <= 1'b0; warn_f <= 1'b0; rstrec_f <= 1'b1;
            reload_q <= RELOAD_RST; warn_q <= '0; winlo_q <= '0; winhi_q <= '0;
        end else begin
            if (acc_wr) begin
                unique case (acc_addr)
                    ADR_CTRL: begin
                        rst_mode <= rst_mode | acc_wdata[CB_MODE];
                        win_en   <= acc_wdata[CB_WIN];
                        if (acc_wdata[CB_TOUT]) tout_f   <= 1'b0;
                        if (acc_wdata[CB_WARN]) warn_f   <= 1'b0;
                        if (acc_wdata[CB_RSTF]) rstrec_f <= 1'b0;
                    end
                    ADR_RELOAD: reload_q <= (wval < FLOOR) ? FLOOR : wval;
                    ADR_WARN:   warn_q   <= wval;
                    ADR_WINLO:  winlo_q  <= wval;
                    ADR_WINHI:  winhi_q  <= wval;
                    default: ;
                endcase
            end
            if (set_tout) tout_f <= 1'b1;
            if (set_warn) warn_f <= 1'b1;
        end
    end
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
    import wwdt_pkg::*;
#(
    parameter int               CNT_W      = 24,
    parameter int               PRE_W      = 2,
    parameter int               DATA_W     = 32,
    parameter int               MIN_RELOAD = 256,
    parameter logic [CNT_W-1:0] RELOAD_RST = 24'h00FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [2:0]        acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              wdt_rst_o,
    output logic              wdt_irq_o
);
    wwdt_state_e      state;
    logic             load, fault, trip, expire, warn_hit, running, win_ok, start_req;
    logic             rst_mode, win_en, tout_f, warn_f, rstrec_f;
    logic [CNT_W-1:0] cnt, reload_q, warn_q, winlo_q, winhi_q;

    assign running   = (state == ST_RUN) || (state == ST_ARMED);
    assign start_req = acc_wr && (acc_addr == ADR_CTRL) && acc_wdata[CB_EN];
    assign win_ok    = !win_en || ((cnt >= winlo_q) && (cnt <= winhi_q));

    wwdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_addr(acc_addr), .key(acc_wdata[7:0]), .start_req(start_req),
        .expire(expire), .win_ok(win_ok), .rst_mode(rst_mode),
        .state(state), .load(load), .fault(fault), .trip(trip)
    );

    wwdt_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(trip), .run(running), .load(load),
        .load_val(reload_q), .warn_val(warn_q), .cnt(cnt),
        .expire(expire), .warn_hit(warn_hit)
    );

    wwdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .MIN_RELOAD(MIN_RELOAD),
                .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .clear(trip), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .set_tout(fault && !rst_mode), .set_warn(warn_hit),
        .rst_mode(rst_mode), .win_en(win_en), .tout_f(tout_f), .warn_f(warn_f),
        .rstrec_f(rstrec_f), .reload_q(reload_q), .warn_q(warn_q),
        .winlo_q(winlo_q), .winhi_q(winhi_q)
    );

    always_comb begin
        acc_rdata = '0;
        unique case (acc_addr)
            ADR_CTRL: begin
                acc_rdata[CB_EN]   = running;
                acc_rdata[CB_MODE] = rst_mode;
                acc_rdata[CB_TOUT] = tout_f;
                acc_rdata[CB_WARN] = warn_f;
                acc_rdata[CB_RSTF] = rstrec_f;
                acc_rdata[CB_WIN]  = win_en;
            end
            ADR_RELOAD: acc_rdata[CNT_W-1:0] = reload_q;
            ADR_COUNT:  acc_rdata[CNT_W-1:0] = cnt;
            ADR_WARN:   acc_rdata[CNT_W-1:0] = warn_q;
            ADR_WINLO:  acc_rdata[CNT_W-1:0] = winlo_q;
            ADR_WINHI:  acc_rdata[CNT_W-1:0] = winhi_q;
            default:    acc_rdata = '0;
        endcase
    end

    assign wdt_rst_o = trip;
    assign wdt_irq_o = tout_f | warn_f;
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
    parameter int CNT_W      = 24,
    parameter int MIN_RELOAD = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_o,
    input logic             running,
    input logic             fault,
    input logic             load,
    input logic             mode,
    input logic             rst_flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1)); // R2
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(reload))); // R3
    AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !fault) |=> running); // R4
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o); // R10
    AST_RST_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> rst_flag); // R10
    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !rst_o) |=> mode); // R11
    AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        reload >= CNT_W'(MIN_RELOAD)); // R12
endmodule

bind wwdt_top wwdt_chk #(.CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_o(wdt_rst_o), .running(running),
    .fault(fault), .load(load), .mode(rst_mode), .rst_flag(rstrec_f),
    .cnt(cnt), .reload(reload_q)
);

// File: tb/wwdt_top_tb.sv
module wwdt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RST_RELOAD = 65535;

    logic        clk = 1'b0, rst_n = 1'b0, acc_wr = 1'b0, acc_rd = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        wdt_rst_o, wdt_irq_o;
    int          tests = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
    );

    // behavioural model: elapsed clocks since load, flags as bits
    int m_ld, m_c, m_rel, m_warn, m_lo, m_hi;
    bit m_on, m_armed, m_mode, m_win, m_tf, m_wf, m_rf, m_trip;

    function automatic int m_cnt();
        return m_ld - m_c / 4;
    endfunction

    function automatic void m_defaults();
        m_on = 0; m_armed = 0; m_mode = 0; m_win = 0; m_tf = 0; m_wf = 0;
        m_trip = 0; m_ld = 0; m_c = 0; m_rel = RST_RELOAD;
        m_warn = 0; m_lo = 0; m_hi = 0;
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return {26'd0, m_win, m_rf, m_wf, m_tf, m_mode, m_on};
            3'd1: return m_rel;
            3'd3: return m_cnt();
            3'd4: return m_warn;
            3'd5: return m_lo;
            3'd6: return m_hi;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_defaults(); m_rf = 0;
        end else if (m_trip) begin
            m_defaults(); m_rf = 1;
        end else begin
            int  cnt;
            bit  tick, expire, whit, feed, fault, load, was_on;
            int  d;
            cnt = m_cnt(); was_on = m_on;
            tick = m_on && (m_c % 4 == 3);
            expire = tick && cnt == 1;
            whit = tick && cnt == m_warn + 1;
            feed = acc_wr && acc_addr == 3'd2;
            fault = 0; load = 0;
            if (!m_on) begin
                if (acc_wr && acc_addr == 3'd0 && acc_wdata[0]) begin m_on = 1; load = 1; end
            end else if (!m_armed) begin
                if (feed) begin
                    if (acc_wdata[7:0] == 8'hAA) m_armed = 1; else fault = 1;
                end else if (expire) fault = 1;
            end else begin
                if (feed && acc_wdata[7:0] == 8'h55) begin
                    if (!m_win || (cnt >= m_lo && cnt <= m_hi)) begin m_armed = 0; load = 1; end
                    else fault = 1;
                end else if (acc_wr || acc_rd) fault = 1;
                else if (expire) fault = 1;
            end
            if (load) begin m_ld = m_rel; m_c = 0; end
            else if (was_on) m_c++;
            if (fault) begin m_on = 0; m_armed = 0; end
            d = acc_wdata[23:0];
            if (acc_wr) begin
                case (acc_addr)
                    3'd0: begin
                        if (fault && m_mode) ; // mode already decides the trip below
                        if (acc_wdata[2]) m_tf = 0;
                        if (acc_wdata[3]) m_wf = 0;
                        if (acc_wdata[4]) m_rf = 0;
                    end
                    3'd1: m_rel = (d < 256) ? 256 : d;
                    3'd4: m_warn = d;
                    3'd5: m_lo = d;
                    3'd6: m_hi = d;
                    default: ;
                endcase
            end
            if (fault && m_mode) m_trip = 1;
            if (fault && !m_mode) m_tf = 1;
            if (whit) m_wf = 1;
            if (acc_wr && acc_addr == 3'd0) begin
                m_mode = m_mode | acc_wdata[1];
                m_win  = acc_wdata[5];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock output compare (R5 R7 R10)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 reset output vs model", wdt_rst_o, m_trip);
            chk("R5 R7 interrupt output vs model", wdt_irq_o, m_tf | m_wf);
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        acc_wr = 1; acc_addr = a; acc_wdata = d;
        @(posedge clk); #1;
        acc_wr = 0; acc_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v, input string tag);
        logic [31:0] e;
        @(negedge clk);
        acc_rd = 1; acc_addr = a;
        #(CLK_PERIOD/4);
        e = m_read(a); v = acc_rdata;
        chk(tag, v, e);
        @(posedge clk); #1;
        acc_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        rd(3'd0, v, "R1 ctrl after reset");   chk("R1 ctrl literal", v, 0);
        rd(3'd3, v, "R1 count after reset");  chk("R1 count literal", v, 0);
        rd(3'd1, v, "R1 reload after reset"); chk("R1 reload literal", v, RST_RELOAD);
        // R12 clamp
        wr(3'd1, 5);
        rd(3'd1, v, "R12 reload clamp"); chk("R12 clamp literal", v, 256);
        wr(3'd1, 300);
        wr(3'd4, 100);
        // start, R2 count steps
        wr(3'd0, 32'h1);
        idle(40);
        rd(3'd3, v, "R2 count after 40 clocks");
        // R4 enable cannot be cleared
        wr(3'd0, 32'h0);
        idle(8);
        rd(3'd0, v, "R4 ctrl after zero write"); chk("R4 enable bit", v[0], 1);
        // R3 valid feed
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'h55);
        rd(3'd3, v, "R3 count after feed"); chk("R3 reload literal", v, 300);
        // R5 warning
        idle(810);
        rd(3'd0, v, "R5 ctrl after warning"); chk("R5 warn flag", v[3], 1);
        // R6 clear warning flag
        wr(3'd0, 32'h8);
        rd(3'd0, v, "R6 ctrl after clear"); chk("R6 warn cleared", v[3], 0);
        // R7 expiry in interrupt mode
        idle(420);
        rd(3'd0, v, "R7 ctrl after expiry");
        chk("R7 tout flag", v[2], 1); chk("R7 stopped", v[0], 0);
        rd(3'd3, v, "R2 count at expiry"); chk("R2 count zero", v, 0);
        wr(3'd0, 32'h4);
        // R8 wrong first key
        wr(3'd0, 32'h1);
        wr(3'd2, 32'h12);
        rd(3'd0, v, "R8 ctrl after bad key"); chk("R8 fault flag", v[2], 1);
        wr(3'd0, 32'h4);
        // R8 access between keys
        wr(3'd0, 32'h1);
        wr(3'd2, 32'hAA);
        rd(3'd0, v, "R8 read between keys");
        rd(3'd0, v, "R8 ctrl after broken pair");
        chk("R8 broken pair flag", v[2], 1); chk("R8 broken pair stop", v[0], 0);
        wr(3'd0, 32'h4);
        // R9 window
        wr(3'd5, 100);
        wr(3'd6, 200);
        wr(3'd0, 32'h21);
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'h55);
        rd(3'd0, v, "R9 ctrl after early feed"); chk("R9 early rejected", v[2], 1);
        wr(3'd0, 32'h24);
        wr(3'd0, 32'h21);
        idle(600);
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'h55);
        rd(3'd3, v, "R9 count after in-window feed"); chk("R9 accepted", v, 300);
        rd(3'd0, v, "R9 ctrl after in-window feed"); chk("R9 no fault", v[2], 0);
        // R11 mode sticky
        wr(3'd0, 32'h2);
        wr(3'd0, 32'h0);
        rd(3'd0, v, "R11 ctrl after zero write"); chk("R11 mode kept", v[1], 1);
        // R10 reset mode trip
        wr(3'd2, 32'h00);
        chk("R10 pulse high", wdt_rst_o, 1);
        @(posedge clk); #1;
        chk("R10 pulse one clock", wdt_rst_o, 0);
        rd(3'd0, v, "R10 ctrl after trip"); chk("R10 record only", v, 32'h10);
        rd(3'd1, v, "R10 reload restored"); chk("R10 reload literal", v, RST_RELOAD);
        // R6 clear record flag
        wr(3'd0, 32'h10);
        rd(3'd0, v, "R6 record cleared"); chk("R6 record literal", v, 0);
        idle(4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule